// File: doc/BRIEF.md
# Nine-bit multidrop address filter

This block sits between a serial receiver and its receive FIFO on a link that uses nine-bit multidrop framing. Each word handed over by the receiver holds eight data bits and a ninth bit; when multidrop framing is on, a ninth bit of 1 marks the word as an address. The block decides, one word at a time, whether the word is written into the FIFO. It also keeps two sticky interrupt flags: one for any address seen, and one for an address equal to this station's address.

Filtering is active only while both the multidrop enable and the filter enable are set. In that state, address words are compared against the station address and are never stored. Data words are written only while the last address seen was a match. With filtering off, every word goes to the FIFO with its ninth bit. The station address is either a full 8-bit configuration value, or the upper nibble of that value joined with four GPIO inputs. The GPIO inputs are synchronized and followed live, so the address changes whenever a pin changes level.

Top module: `mdrop_addr_filter`

## Requirements
- R1: A FIFO write carries the ninth bit in `fifo_wdata[8]` and the eight data bits in `fifo_wdata[7:0]`. With `cfg_multidrop_en` high, a ninth bit of 1 marks an address word.
- R2: `par_err` pulses high one cycle after `rx_valid` with `rx_par_err` set, but only when `cfg_multidrop_en` is low. In multidrop mode it stays low.
- R3: Unless both `cfg_multidrop_en` and `cfg_filter_en` are high, every word with `rx_valid` produces `fifo_wr` one cycle later, carrying the word unchanged.
- R4: In multidrop mode every address word sets `irq_addr`, whether or not it matches. The flag stays set until it is cleared.
- R5: While filtering, data words that follow a matching address are written to the FIFO.
- R6: While filtering, data words that follow a non-matching address are dropped.
- R7: While filtering, address words are never written to the FIFO.
- R8: While filtering, an address word equal to the station address sets the sticky flag `irq_match`.
- R9: With `cfg_gpio_addr_en` high, the station address is `{cfg_station_addr[7:4], gpio_in[3:0]}`, and `cfg_station_addr[3:0]` is ignored. With it low, the station address is `cfg_station_addr`.
- R10: A level change on `gpio_in` reaches the address compare after exactly two clock edges. An address word in the cycle right after the change is still compared with the old value.
- R11: After reset, and whenever filtering is switched off and back on, data words are dropped until a matching address arrives.
- R12: `irq_clr` clears both flags on the next edge. A set event in the same cycle wins over the clear.
- R13: During and after reset, `fifo_wr`, `par_err`, `irq_addr` and `irq_match` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_multidrop_en | input | 1 | Enables nine-bit multidrop framing |
| cfg_filter_en | input | 1 | Enables automatic address filtering (only with multidrop) |
| cfg_gpio_addr_en | input | 1 | Takes the station address's low nibble from `gpio_in` |
| cfg_station_addr | input | 8 | Station address register value |
| gpio_in | input | 4 | Asynchronous GPIO inputs for the low address nibble |
| rx_valid | input | 1 | One-cycle strobe: a received word is present |
| rx_bit9 | input | 1 | Ninth bit of the received word |
| rx_data | input | 8 | Eight data bits of the received word |
| rx_par_err | input | 1 | Parity error reported by the receiver |
| irq_clr | input | 1 | Clears both interrupt flags |
| fifo_wr | output | 1 | FIFO write strobe (registered) |
| fifo_wdata | output | 9 | Word written to the FIFO, ninth bit at the top |
| par_err | output | 1 | Parity error pulse, masked in multidrop mode |
| irq_addr | output | 1 | Sticky flag: an address word was received |
| irq_match | output | 1 | Sticky flag: the station's address was received |

## Verification
The bench sends data words before any address has arrived. A design that starts with the gate open would pass them to the FIFO. The same check is repeated after filtering is switched off and back on, to catch a gate that keeps its old state. It sends an address word in the cycle right after a GPIO change. A design with too few or too many synchronizer stages matches at the wrong time. It also sets a register low nibble that differs from the GPIO value, which exposes a design that reads the wrong source for the low nibble. Finally, it fires a clear in the same cycle as a new address word: a design where the clear wins loses the interrupt.

// File: rtl/mdrop_pkg.sv
package mdrop_pkg;
  localparam int unsigned DATA_W_DEF = 8;
  localparam int unsigned GPIO_W_DEF = 4;
  localparam int unsigned SYNC_DEF   = 2;
endpackage

// File: rtl/mdrop_gpio_sync.sv
module mdrop_gpio_sync #(
  parameter int unsigned WIDTH  = 4,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);
  logic [WIDTH-1:0] chain [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < int'(STAGES); i++) chain[i] <= '0;
    end else begin
      chain[0] <= async_in;
      for (int i = 1; i < int'(STAGES); i++) chain[i] <= chain[i-1];
    end
  end

  assign sync_out = chain[STAGES-1];
endmodule

// File: rtl/mdrop_addr_cmp.sv
module mdrop_addr_cmp #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned GPIO_W = 4
) (
  input  logic              use_gpio,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [GPIO_W-1:0] gpio_bits,
  input  logic [ADDR_W-1:0] rx_addr,
  output logic              hit
);
  logic [ADDR_W-1:0] station;

  generate
    if (GPIO_W < ADDR_W) begin : g_mix
      always_comb station = use_gpio ? {reg_addr[ADDR_W-1:GPIO_W], gpio_bits} : reg_addr;
    end else begin : g_full
      always_comb station = use_gpio ? gpio_bits[ADDR_W-1:0] : reg_addr;
    end
  endgenerate

  assign hit = (station == rx_addr);
endmodule

// File: rtl/mdrop_irq_flags.sv
module mdrop_irq_flags #(
  parameter int unsigned N = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set_evt,
  input  logic         clr,
  output logic [N-1:0] flags
);
  generate
    for (genvar g = 0; g < int'(N); g++) begin : g_flag
      always_ff @(posedge clk) begin
        if (rst)             flags[g] <= 1'b0;
        else if (set_evt[g]) flags[g] <= 1'b1;
        else if (clr)        flags[g] <= 1'b0;
      end
    end
  endgenerate
endmodule

// File: rtl/mdrop_addr_filter.sv
module mdrop_addr_filter #(
  parameter int unsigned DATA_W = mdrop_pkg::DATA_W_DEF,
  parameter int unsigned GPIO_W = mdrop_pkg::GPIO_W_DEF,
  parameter int unsigned SYNC_N = mdrop_pkg::SYNC_DEF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_multidrop_en,
  input  logic              cfg_filter_en,
  input  logic              cfg_gpio_addr_en,
  input  logic [DATA_W-1:0] cfg_station_addr,
  input  logic [GPIO_W-1:0] gpio_in,
  input  logic              rx_valid,
  input  logic              rx_bit9,
  input  logic [DATA_W-1:0] rx_data,
  input  logic              rx_par_err,
  input  logic              irq_clr,
  output logic              fifo_wr,
  output logic [DATA_W:0]   fifo_wdata,
  output logic              par_err,
  output logic              irq_addr,
  output logic              irq_match
);
  localparam int unsigned FLAG_N = 2;

  logic [GPIO_W-1:0] gpio_s;
  logic              hit;
  logic              filt_on;
  logic              addr_word;
  logic              gate_open;
  logic [FLAG_N-1:0] flag_set;
  logic [FLAG_N-1:0] flag_q;

  mdrop_gpio_sync #(.WIDTH(GPIO_W), .STAGES(SYNC_N)) u_sync (
    .clk(clk), .rst(rst), .async_in(gpio_in), .sync_out(gpio_s)
  );

  mdrop_addr_cmp #(.ADDR_W(DATA_W), .GPIO_W(GPIO_W)) u_cmp (
    .use_gpio(cfg_gpio_addr_en), .reg_addr(cfg_station_addr),
    .gpio_bits(gpio_s), .rx_addr(rx_data), .hit(hit)
  );

  assign filt_on   = cfg_multidrop_en & cfg_filter_en;
  assign addr_word = rx_valid & cfg_multidrop_en & rx_bit9;
  assign flag_set  = {addr_word & filt_on & hit, addr_word};

  mdrop_irq_flags #(.N(FLAG_N)) u_flags (
    .clk(clk), .rst(rst), .set_evt(flag_set), .clr(irq_clr), .flags(flag_q)
  );

  assign irq_addr  = flag_q[0];
  assign irq_match = flag_q[1];

  always_ff @(posedge clk) begin
    if (rst) begin
      fifo_wr    <= 1'b0;
      fifo_wdata <= '0;
      par_err    <= 1'b0;
      gate_open  <= 1'b0;
    end else begin
      fifo_wr    <= rx_valid & (~filt_on | (~rx_bit9 & gate_open));
      fifo_wdata <= {rx_bit9, rx_data};
      par_err    <= rx_valid & rx_par_err & ~cfg_multidrop_en;
      if (!filt_on)       gate_open <= 1'b0;
      else if (addr_word) gate_open <= hit;
    end
  end
endmodule

// File: rtl/mdrop_addr_filter_chk.sv
module mdrop_addr_filter_chk #(
  parameter int unsigned DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              cfg_multidrop_en,
  input logic              cfg_filter_en,
  input logic              rx_valid,
  input logic              rx_bit9,
  input logic [DATA_W-1:0] rx_data,
  input logic              irq_clr,
  input logic              fifo_wr,
  input logic [DATA_W:0]   fifo_wdata,
  input logic              par_err,
  input logic              irq_addr,
  input logic              irq_match
);
  AST_ADDR_NEVER_STORED: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && rx_bit9 && cfg_multidrop_en && cfg_filter_en) |=> !fifo_wr); // R7
  AST_ADDR_FLAG_SET: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && rx_bit9 && cfg_multidrop_en) |=> irq_addr); // R4
  AST_PASS_UNFILTERED: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && !(cfg_multidrop_en && cfg_filter_en)) |=>
      (fifo_wr && fifo_wdata == {$past(rx_bit9), $past(rx_data)})); // R3
  AST_PARITY_MASKED: assert property (@(posedge clk) disable iff (rst)
    cfg_multidrop_en |=> !par_err); // R2
  AST_MATCH_HAS_ADDR: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_match) |-> irq_addr); // R8
  AST_NO_SPURIOUS_WR: assert property (@(posedge clk) disable iff (rst)
    !rx_valid |=> !fifo_wr); // R1
  AST_CLEAR_WORKS: assert property (@(posedge clk) disable iff (rst)
    (irq_clr && !rx_valid) |=> (!irq_addr && !irq_match)); // R12
endmodule

bind mdrop_addr_filter mdrop_addr_filter_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .cfg_multidrop_en(cfg_multidrop_en),
  .cfg_filter_en(cfg_filter_en), .rx_valid(rx_valid), .rx_bit9(rx_bit9),
  .rx_data(rx_data), .irq_clr(irq_clr), .fifo_wr(fifo_wr),
  .fifo_wdata(fifo_wdata), .par_err(par_err), .irq_addr(irq_addr),
  .irq_match(irq_match)
);

// File: tb/mdrop_addr_filter_test.sv
`timescale 1ns/1ps
module mdrop_addr_filter_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       md = 1'b0, fe = 1'b0, ge = 1'b0;
  logic [7:0] st_addr = 8'h00;
  logic [3:0] gpio = 4'h0;
  logic       rx_valid = 1'b0, rx_bit9 = 1'b0, rx_par_err = 1'b0, irq_clr = 1'b0;
  logic [7:0] rx_data = 8'h00;
  logic       fifo_wr, par_err, irq_addr, irq_match;
  logic [8:0] fifo_wdata;
  int         n_run = 0, n_fail = 0;
  bit         done = 1'b0;

  always #2.5 clk = ~clk;

  mdrop_addr_filter uut (
    .clk(clk), .rst(rst), .cfg_multidrop_en(md), .cfg_filter_en(fe),
    .cfg_gpio_addr_en(ge), .cfg_station_addr(st_addr), .gpio_in(gpio),
    .rx_valid(rx_valid), .rx_bit9(rx_bit9), .rx_data(rx_data),
    .rx_par_err(rx_par_err), .irq_clr(irq_clr), .fifo_wr(fifo_wr),
    .fifo_wdata(fifo_wdata), .par_err(par_err), .irq_addr(irq_addr),
    .irq_match(irq_match)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // drive one word for one edge, leave outputs of that edge visible
  task automatic send(input bit b9, input logic [7:0] d, input bit pe = 1'b0, input bit clr = 1'b0);
    rx_valid = 1'b1; rx_bit9 = b9; rx_data = d; rx_par_err = pe; irq_clr = clr;
    @(negedge clk);
    rx_valid = 1'b0; rx_bit9 = 1'b0; rx_par_err = 1'b0; irq_clr = 1'b0;
  endtask

  task automatic clear_flags();
    irq_clr = 1'b1;
    @(negedge clk);
    irq_clr = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic t_reset();
    rst = 1'b1; idle(3);
    check(!fifo_wr && !par_err && !irq_addr && !irq_match, "R13 reset state",
          {fifo_wr, par_err, irq_addr, irq_match}, 0);
    rst = 1'b0; idle(1);
  endtask

  task automatic t_plain();
    md = 0; fe = 1;
    send(0, 8'h5A);
    check(fifo_wr && fifo_wdata == 9'h05A, "R3 plain data passes", fifo_wdata, 9'h05A);
    send(1, 8'h33, 1);
    check(fifo_wr && fifo_wdata == 9'h133, "R1 ninth bit at top", fifo_wdata, 9'h133);
    check(par_err, "R2 parity error reported outside multidrop", par_err, 1);
    check(!irq_addr, "R4 no address flag outside multidrop", irq_addr, 0);
  endtask

  task automatic t_md_nofilter();
    md = 1; fe = 0; st_addr = 8'h77;
    send(1, 8'h12, 1);
    check(fifo_wr && fifo_wdata == 9'h112, "R3 address passes without filter", fifo_wdata, 9'h112);
    check(!par_err, "R2 parity masked in multidrop", par_err, 0);
    check(irq_addr && !irq_match, "R4 address flag set", {irq_addr, irq_match}, 2'b10);
    clear_flags();
    check(!irq_addr, "R12 clear removes flag", irq_addr, 0);
  endtask

  task automatic t_filter();
    md = 1; fe = 1; ge = 0; st_addr = 8'hA5;
    idle(1);
    send(0, 8'h11);
    check(!fifo_wr, "R11 data dropped before first match", fifo_wr, 0);
    send(1, 8'h3C);
    check(!fifo_wr, "R7 address not stored", fifo_wr, 0);
    check(irq_addr && !irq_match, "R4 non-matching address flagged", {irq_addr, irq_match}, 2'b10);
    send(0, 8'h22);
    check(!fifo_wr, "R6 data after non-match dropped", fifo_wr, 0);
    send(1, 8'hA5);
    check(!fifo_wr, "R7 matching address not stored", fifo_wr, 0);
    check(irq_match, "R8 match flag set", irq_match, 1);
    send(0, 8'h77);
    check(fifo_wr && fifo_wdata == 9'h077, "R5 data after match written", fifo_wdata, 9'h077);
    fe = 0; idle(1); fe = 1;
    send(0, 8'h44);
    check(!fifo_wr, "R11 gate closed after re-enable", fifo_wr, 0);
  endtask

  task automatic t_gpio();
    md = 1; fe = 1; ge = 1; st_addr = 8'h9F; gpio = 4'h6;
    idle(3); clear_flags();
    send(1, 8'h9F);
    check(!irq_match, "R9 register low nibble ignored", irq_match, 0);
    send(1, 8'h96);
    check(irq_match, "R9 gpio nibble forms address", irq_match, 1);
    send(0, 8'h5E);
    check(fifo_wr && fifo_wdata == 9'h05E, "R9 data after gpio match", fifo_wdata, 9'h05E);
    clear_flags();
    gpio = 4'h3;
    @(negedge clk);
    send(1, 8'h93);
    check(!irq_match, "R10 old gpio still used one edge after change", irq_match, 0);
    send(1, 8'h93);
    check(irq_match, "R10 new gpio used after two edges", irq_match, 1);
    ge = 0;
  endtask

  task automatic t_clear_collision();
    md = 1; fe = 1; st_addr = 8'h42;
    clear_flags();
    send(1, 8'h42, 0, 1);
    check(irq_addr && irq_match, "R12 set wins over clear", {irq_addr, irq_match}, 2'b11);
    clear_flags();
    check(!irq_addr && !irq_match, "R12 clear alone", {irq_addr, irq_match}, 0);
  endtask

  initial begin
    idle(1);
    t_reset();
    t_plain();
    t_md_nofilter();
    t_filter();
    t_gpio();
    t_clear_collision();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule